// File: doc/BRIEF.md
# Video-Priority DRAM Access Controller

This block arbitrates one DRAM array between a processor with an 8-bit data path and a display engine that must read screen data on a fixed schedule. Two upper address lines split the on-board space into four 64 KB regions: boot ROM, peripheral I/O, and two RAM banks. ROM reads are decoded combinationally and never wait. RAM and I/O accesses run through a fixed DRAM strobe sequence. That sequence drives row strobe, one column strobe per bank, write enable and the row/column address-mux select. The processor is held off through its acknowledge line until data is valid or has been taken.

A single-clock fetch pulse stands in for the display timing. Each fetch takes a four-clock strobe window. The window has absolute priority: a processor request that arrives during the window, or on the same edge as the fetch, waits until the window ends. While a fetch owns the array, the video-ownership output switches the processor address multiplexers off and the transceiver enable stays inactive. I/O cycles run a row-strobe-only sequence with no column strobe, so the array only sees a refresh. Depending on address bit 6, that sequence either enables the peripheral chip or writes an internal 8-bit control register.

Top module: `vmem_ctrl`

## Requirements
- R1: `rom_oe_o` is 1 exactly when A17=0, A16=0, `ds_ni`=0 and `rw_i`=1. A ROM-region access starts no DRAM sequence, never drives `dtack_no` low and leaves every strobe inactive.
- R2: After reset, `ras_no`, both `cas_no` bits, `we_no`, `dtack_no`, `txoe_no` and `pcen_no` are 1, while `col_sel_o`, `vda_o` and `ctrl_reg_o` are 0.
- R3: A processor RAM or I/O request seen at an idle edge runs one phase per clock. The phases are: row strobe low; then `col_sel_o`=1; then the column phase; then `dtack_no`=0. `dtack_no` stays low while `ds_ni` stays low. One precharge clock with all strobes inactive follows the release of `ds_ni`, and the controller then returns to idle.
- R4: For a RAM access, A16=0 drives `cas_no[0]` low and A16=1 drives `cas_no[1]` low, from the column phase through the acknowledge phase. At no time are both column strobes low.
- R5: `we_no` is low from the column-select phase through the acknowledge phase of a RAM write (`rw_i`=0). It stays high for reads and for all I/O cycles.
- R6: An I/O access (A17=0, A16=1) with A6=0 still runs the row strobe but asserts no column strobe. It drives `pcen_no` low in the column and acknowledge phases, and it leaves `ctrl_reg_o` unchanged.
- R7: An I/O write with A6=1 keeps `pcen_no` high and loads `data_i` into `ctrl_reg_o` on the edge at which `dtack_no` falls. An I/O read with A6=1 leaves `ctrl_reg_o` unchanged.
- R8: A `fetch_req_i` pulse seen at an idle edge starts a four-clock window with `vda_o`=1 throughout. The row strobe is low in clocks 1 to 3, `col_sel_o` is 1 in clocks 2 and 3, and `cas_no[0]` is low in clock 3. Clock 4 is precharge, and the controller returns to idle afterwards.
- R9: A fetch has priority over a processor request seen on the same edge or during the window. The processor sequence starts at the second edge after the window ends, and `dtack_no` and `txoe_no` stay high until then.
- R10: A fetch pulse that arrives during a processor cycle is remembered. Its window starts on the edge after the processor cycle has returned to idle.
- R11: `txoe_no` is low from the row-strobe phase through the acknowledge phase of a processor RAM or I/O cycle, and high at all other times.
- R12: `vda_o` is 0 throughout every processor cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a17_i | input | 1 | Address bit 17, region select high bit |
| a16_i | input | 1 | Address bit 16, region select low bit / bank |
| a6_i | input | 1 | Address bit 6, peripheral vs control register |
| ds_ni | input | 1 | Processor data strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| data_i | input | 8 | Processor data bus for control register writes |
| fetch_req_i | input | 1 | Single-clock screen fetch request |
| rom_oe_o | output | 1 | ROM output enable, active high |
| ras_no | output | 1 | DRAM row strobe, active low |
| cas_no | output | 2 | DRAM column strobes per bank, active low |
| we_no | output | 1 | DRAM write enable, active low |
| col_sel_o | output | 1 | Address mux select, 1 = column |
| vda_o | output | 1 | Display owns DRAM; disables processor address mux |
| txoe_no | output | 1 | Data transceiver enable, active low |
| dtack_no | output | 1 | Data acknowledge to processor, active low |
| pcen_no | output | 1 | Peripheral chip enable, active low |
| ctrl_reg_o | output | 8 | Internal control register contents |

## Verification
The bench starts a fetch and a RAM write on the same edge. A controller that let the processor win would pull `dtack_no` or `txoe_no` low inside the display window. It also pulses a fetch during a long acknowledge hold. A design that dropped the request would never raise `vda_o` afterwards, and one that started the fetch at once would break the held acknowledge. For I/O cycles, the bench checks on both values of A6 that no column strobe fires and that the control register moves only on a register write, never on a peripheral write or a register read. Bank steering is checked in both directions, and a RAM access with A6=1 must not touch the register.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_V_RAS, ST_V_COL, ST_V_CAS, ST_V_PRE,
    ST_C_RAS, ST_C_COL, ST_C_CAS, ST_C_ACK, ST_C_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    RG_ROM  = 2'b00,
    RG_IO   = 2'b01,
    RG_RAM0 = 2'b10,
    RG_RAM1 = 2'b11
  } region_e;
endpackage

// File: rtl/vmem_decode.sv
module vmem_decode
  import vmem_pkg::*;
(
  input  logic    a17_i,
  input  logic    a16_i,
  input  logic    ds_ni,
  input  logic    rw_i,
  output region_e region_o,
  output logic    cpu_req_o,
  output logic    rom_oe_o
);
  assign region_o  = region_e'({a17_i, a16_i});
  // ROM bypasses arbitration entirely
  assign rom_oe_o  = !ds_ni && rw_i && (region_o == RG_ROM);
  assign cpu_req_o = !ds_ni && (region_o != RG_ROM);
endmodule

// File: rtl/vmem_creg.sv
module vmem_creg #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= data_i;
  end
endmodule

// File: rtl/vmem_seq.sv
module vmem_seq
  import vmem_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int VID_BANK  = 0,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_req_i,
  input  logic                 ds_ni,
  input  region_e              region_i,
  input  logic                 a6_i,
  input  logic                 rw_i,
  input  logic                 fetch_req_i,
  output logic                 ras_no,
  output logic [NUM_BANKS-1:0] cas_no,
  output logic                 we_no,
  output logic                 col_sel_o,
  output logic                 vda_o,
  output logic                 txoe_no,
  output logic                 dtack_no,
  output logic                 pcen_no,
  output logic                 reg_wr_o
);
  seq_state_e state_q, state_d;
  logic fetch_pend_q;
  logic lat_ram_q, lat_wr_q, lat_peri_q, lat_reg_q;
  logic [BANK_W-1:0] lat_bank_q;
  logic fetch_hit, grant_cpu, grant_vid;
  logic cpu_cas, vid_cas;

  assign fetch_hit = fetch_req_i || fetch_pend_q;
  assign grant_vid = (state_q == ST_IDLE) && fetch_hit;
  assign grant_cpu = (state_q == ST_IDLE) && !fetch_hit && cpu_req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (grant_vid)      state_d = ST_V_RAS;
        else if (grant_cpu) state_d = ST_C_RAS;
      end
      ST_V_RAS: state_d = ST_V_COL;
      ST_V_COL: state_d = ST_V_CAS;
      ST_V_CAS: state_d = ST_V_PRE;
      ST_V_PRE: state_d = ST_IDLE;
      ST_C_RAS: state_d = ST_C_COL;
      ST_C_COL: state_d = ST_C_CAS;
      ST_C_CAS: state_d = ST_C_ACK;
      ST_C_ACK: if (ds_ni) state_d = ST_C_PRE;
      ST_C_PRE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      fetch_pend_q <= 1'b0;
      lat_ram_q    <= 1'b0;
      lat_wr_q     <= 1'b0;
      lat_peri_q   <= 1'b0;
      lat_reg_q    <= 1'b0;
      lat_bank_q   <= '0;
    end else begin
      state_q      <= state_d;
      fetch_pend_q <= fetch_hit && !grant_vid;
      if (grant_cpu) begin
        lat_ram_q  <= region_i[1];
        lat_bank_q <= BANK_W'(region_i[0]);
        lat_wr_q   <= !rw_i;
        lat_peri_q <= (region_i == RG_IO) && !a6_i;
        lat_reg_q  <= (region_i == RG_IO) && a6_i && !rw_i;
      end
    end
  end

  assign cpu_cas = state_q inside {ST_C_CAS, ST_C_ACK};
  assign vid_cas = (state_q == ST_V_CAS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cas
    assign cas_no[b] = !((cpu_cas && lat_ram_q && (lat_bank_q == BANK_W'(b))) ||
                         (vid_cas && (VID_BANK == b)));
  end

  assign ras_no    = !(state_q inside {ST_V_RAS, ST_V_COL, ST_V_CAS,
                                       ST_C_RAS, ST_C_COL, ST_C_CAS, ST_C_ACK});
  assign col_sel_o = state_q inside {ST_V_COL, ST_V_CAS, ST_C_COL, ST_C_CAS, ST_C_ACK};
  assign we_no     = !(lat_ram_q && lat_wr_q && (state_q inside {ST_C_COL, ST_C_CAS, ST_C_ACK}));
  assign vda_o     = state_q inside {ST_V_RAS, ST_V_COL, ST_V_CAS, ST_V_PRE};
  assign txoe_no   = !(state_q inside {ST_C_RAS, ST_C_COL, ST_C_CAS, ST_C_ACK});
  assign dtack_no  = (state_q != ST_C_ACK);
  assign pcen_no   = !(cpu_cas && lat_peri_q);
  // register loads on the edge that enters the acknowledge phase
  assign reg_wr_o  = (state_q == ST_C_CAS) && lat_reg_q;
endmodule

// File: rtl/vmem_ctrl.sv
module vmem_ctrl
  import vmem_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int VID_BANK  = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 a17_i,
  input  logic                 a16_i,
  input  logic                 a6_i,
  input  logic                 ds_ni,
  input  logic                 rw_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 fetch_req_i,
  output logic                 rom_oe_o,
  output logic                 ras_no,
  output logic [NUM_BANKS-1:0] cas_no,
  output logic                 we_no,
  output logic                 col_sel_o,
  output logic                 vda_o,
  output logic                 txoe_no,
  output logic                 dtack_no,
  output logic                 pcen_no,
  output logic [DATA_W-1:0]    ctrl_reg_o
);
  region_e region;
  logic    cpu_req;
  logic    reg_wr;

  vmem_decode i_decode (
    .a17_i, .a16_i, .ds_ni, .rw_i,
    .region_o (region),
    .cpu_req_o(cpu_req),
    .rom_oe_o
  );

  vmem_seq #(.NUM_BANKS(NUM_BANKS), .VID_BANK(VID_BANK)) i_seq (
    .clk_i, .rst_ni,
    .cpu_req_i(cpu_req),
    .ds_ni,
    .region_i (region),
    .a6_i, .rw_i, .fetch_req_i,
    .ras_no, .cas_no, .we_no, .col_sel_o, .vda_o,
    .txoe_no, .dtack_no, .pcen_no,
    .reg_wr_o (reg_wr)
  );

  vmem_creg #(.DATA_W(DATA_W)) i_creg (
    .clk_i, .rst_ni,
    .wr_i  (reg_wr),
    .data_i,
    .q_o   (ctrl_reg_o)
  );
endmodule

// File: rtl/vmem_ctrl_chk.sv
module vmem_ctrl_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ds_ni,
  input logic                 rom_oe_o,
  input logic                 ras_no,
  input logic [NUM_BANKS-1:0] cas_no,
  input logic                 col_sel_o,
  input logic                 vda_o,
  input logic                 txoe_no,
  input logic                 dtack_no,
  input logic                 pcen_no,
  input logic [DATA_W-1:0]    ctrl_reg_o
);
  // R1
  rom_no_xcvr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_oe_o |-> txoe_no && pcen_no);
  // R3
  dtack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && !ds_ni) |=> !dtack_no);
  // R3
  dtack_in_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtack_no) |-> !ras_no && col_sel_o);
  // R4
  one_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~cas_no) <= 1);
  // R6
  io_no_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pcen_no |-> (&cas_no) && !ras_no);
  // R7
  reg_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_reg_o != $past(ctrl_reg_o)) |-> $fell(dtack_no));
  // R9
  vid_blocks_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vda_o |-> txoe_no && dtack_no && pcen_no);
  // R11
  xcvr_in_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txoe_no |-> !ras_no && !vda_o);
endmodule

bind vmem_ctrl vmem_ctrl_chk #(.DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) i_chk (
  .clk_i, .rst_ni, .ds_ni, .rom_oe_o, .ras_no, .cas_no, .col_sel_o,
  .vda_o, .txoe_no, .dtack_no, .pcen_no, .ctrl_reg_o
);

// File: tb/test_vmem_ctrl.sv
module test_vmem_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a17 = 1'b0, a16 = 1'b0, a6 = 1'b0, ds_n = 1'b1, rw = 1'b1, fetch = 1'b0;
  logic [7:0] data = '0;
  logic rom_oe, ras_n, we_n, col_sel, vda, txoe_n, dtack_n, pcen_n;
  logic [1:0] cas_n;
  logic [7:0] creg;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_reg = '0;

  always #10 clk = ~clk;

  vmem_ctrl i_vmem_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .a17_i(a17), .a16_i(a16), .a6_i(a6),
    .ds_ni(ds_n), .rw_i(rw), .data_i(data), .fetch_req_i(fetch),
    .rom_oe_o(rom_oe), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .col_sel_o(col_sel), .vda_o(vda), .txoe_no(txoe_n), .dtack_no(dtack_n),
    .pcen_no(pcen_n), .ctrl_reg_o(creg)
  );

  // {ras, col, cas1, cas0, we, dtack, txoe, pcen, vda}
  wire [8:0] bus = {ras_n, col_sel, cas_n[1], cas_n[0], we_n, dtack_n, txoe_n, pcen_n, vda};
  localparam logic [8:0] IDLE_V = 9'b1_0_11_1_1_1_1_0;

  function automatic logic [8:0] cpu_v(int ph, int kind, int bank, bit wr);
    bit act = (ph <= 3), casp = (ph == 2 || ph == 3);
    return {!act, (ph >= 1 && ph <= 3),
            !(kind == 0 && casp && bank == 1), !(kind == 0 && casp && bank == 0),
            !(kind == 0 && wr && ph >= 1 && ph <= 3), !(ph == 3), !act,
            !(kind == 1 && casp), 1'b0};
  endfunction

  function automatic logic [8:0] vid_v(int ph);
    return {!(ph <= 2), (ph == 1 || ph == 2), 1'b1, !(ph == 2), 4'b1111, 1'b1};
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_bus(logic [8:0] exp, string tag);
    chk(bus === exp, tag, 32'(bus), 32'(exp));
  endtask

  // kind: 0 RAM, 1 I/O peripheral (A6=0), 2 I/O register (A6=1)
  task automatic run_cpu(int kind, int bank, bit wr, int hold, logic [7:0] d, string tag);
    a17 = (kind == 0); a16 = (kind == 0) ? bank[0] : 1'b1;
    a6 = (kind != 1); rw = !wr; data = d; ds_n = 1'b0;
    for (int ph = 0; ph < 4; ph++) begin
      step();
      chk_bus(cpu_v(ph, kind, bank, wr), tag);
    end
    if (kind == 2 && wr) exp_reg = d;
    chk(creg === exp_reg, {tag, " R7 reg"}, 32'(creg), 32'(exp_reg));
    for (int h = 0; h < hold; h++) begin
      step();
      chk_bus(cpu_v(3, kind, bank, wr), {tag, " R3 hold"});
    end
    ds_n = 1'b1; rw = 1'b1;
    step(); chk_bus(cpu_v(4, kind, bank, wr), {tag, " R3 pre"});
    step(); chk_bus(IDLE_V, {tag, " R3 idle"});
    chk(creg === exp_reg, {tag, " R6 reg"}, 32'(creg), 32'(exp_reg));
  endtask

  task automatic t_reset();
    chk_bus(IDLE_V, "R2 strobes");
    chk(creg === 8'h00, "R2 reg", 32'(creg), 0);
    chk(rom_oe === 1'b0, "R2 rom", 32'(rom_oe), 0);
  endtask

  task automatic t_rom();
    a17 = 0; a16 = 0; rw = 1; ds_n = 0; #1;
    chk(rom_oe === 1'b1, "R1 rom read", 32'(rom_oe), 1);
    for (int i = 0; i < 3; i++) begin
      step(); chk_bus(IDLE_V, "R1 no wait");
    end
    rw = 0; #1;
    chk(rom_oe === 1'b0, "R1 rom write", 32'(rom_oe), 0);
    step(); chk_bus(IDLE_V, "R1 rom write idle");
    ds_n = 1; rw = 1; #1;
    chk(rom_oe === 1'b0, "R1 strobe off", 32'(rom_oe), 0);
    a17 = 1; #1;
    chk(rom_oe === 1'b0, "R1 ram region", 32'(rom_oe), 0);
    step();
  endtask

  task automatic t_video();
    fetch = 1;
    step(); fetch = 0; chk_bus(vid_v(0), "R8 w0");
    for (int ph = 1; ph < 4; ph++) begin
      step(); chk_bus(vid_v(ph), "R8 window");
    end
    step(); chk_bus(IDLE_V, "R8 end");
    step(); chk_bus(IDLE_V, "R8 no repeat");
  endtask

  task automatic t_same_edge();
    a17 = 1; a16 = 1; a6 = 0; rw = 0; data = 8'h3C; ds_n = 0; fetch = 1;
    step(); fetch = 0; chk_bus(vid_v(0), "R9 fetch wins");
    for (int ph = 1; ph < 4; ph++) begin
      step(); chk_bus(vid_v(ph), "R9 cpu waits");
    end
    step(); chk_bus(IDLE_V, "R9 idle gap");
    for (int ph = 0; ph < 4; ph++) begin
      step(); chk_bus(cpu_v(ph, 0, 1, 1), "R9 R12 late cpu");
    end
    ds_n = 1; rw = 1;
    step(); chk_bus(IDLE_V, "R9 pre");
    step(); chk_bus(IDLE_V, "R9 done");
  endtask

  task automatic t_fetch_in_cpu();
    a17 = 1; a16 = 0; a6 = 1; rw = 1; ds_n = 0;
    for (int ph = 0; ph < 4; ph++) begin
      step(); chk_bus(cpu_v(ph, 0, 0, 0), "R10 cpu");
    end
    fetch = 1;
    step(); fetch = 0; chk_bus(cpu_v(3, 0, 0, 0), "R10 ack kept");
    step(); chk_bus(cpu_v(3, 0, 0, 0), "R10 ack kept");
    ds_n = 1;
    step(); chk_bus(IDLE_V, "R10 pre");
    step(); chk_bus(IDLE_V, "R10 idle");
    for (int ph = 0; ph < 4; ph++) begin
      step(); chk_bus(vid_v(ph), "R10 deferred fetch");
    end
    step(); chk_bus(IDLE_V, "R10 end");
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_rom();
    run_cpu(0, 0, 0, 0, 8'h00, "R3 R4 R11 ram0 read");
    run_cpu(0, 1, 1, 2, 8'hFF, "R4 R5 R12 ram1 write");
    run_cpu(0, 0, 1, 1, 8'h77, "R5 ram0 write");
    run_cpu(1, 0, 1, 0, 8'h99, "R6 io periph write");
    run_cpu(1, 0, 0, 1, 8'h00, "R6 io periph read");
    run_cpu(2, 0, 1, 0, 8'hA5, "R7 reg write");
    run_cpu(2, 0, 0, 0, 8'h12, "R7 reg read");
    run_cpu(2, 0, 1, 3, 8'h5A, "R7 reg rewrite");
    t_video();
    t_same_edge();
    t_fetch_in_cpu();
    run_cpu(0, 1, 0, 0, 8'h00, "R3 after video");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule